// File: doc/BRIEF.md
# Line Interrupt Status Register

This block keeps one pending flag and one enable flag for each input line of a general-purpose I/O bank. It turns those flags into one interrupt request per line. Each line input arrives already debounced and already corrected for polarity, so the detector only ever looks for a rising edge or a high level. Falling-edge or active-low sources are handled by inverting the line further upstream.

Each line has a configuration pair from outside the block. One bit turns detection on for the line. The other bit picks edge capture (1) or level capture (0). Software reaches the flags through one word per line at `BASE_ADDR + 8*line`. In that word, separate write-one bits clear the pending flag, set the pending flag, clear the enable and set the enable, so a write never needs a read first. A read returns the pending flag and the enable. Each request output is meant to drive its own message-signalled vector; vector delivery itself lies outside the block.

Top module: `lineirq_status`

## Requirements
- R1: After reset every pending flag and every enable flag is 0, every line word reads 0 and every request output is 0.
- R2: Line i owns the word at address `BASE_ADDR + 8*i`. A write to an address that is below the base, not a multiple of 8 from it, or beyond the last line changes no flag. A read from such an address returns 0.
- R3: With detection on and edge mode selected, a 0-to-1 change of the line input sets the pending flag one clock later. The flag then stays set while the input stays high, and after the input falls, until software clears it.
- R4: Write bit 0 = 1 clears the pending flag and write bit 1 = 1 sets it. The set works whether or not detection is on. When a set, from hardware or software, coincides with a clear in the same cycle, the flag ends up set.
- R5: With detection on and level mode selected, a high line input sets the pending flag every cycle. A clear write has no effect while the input is still high. Once the input is low, the flag stays set until a clear write removes it.
- R6: Write bit 3 = 1 sets the enable and write bit 2 = 1 clears it. When both are written together the enable ends up set.
- R7: A line word reads back the pending flag in bit 0 and the enable in bit 1; bits 3:2 read 0.
- R8: Each request output is the AND of that line's pending flag, its enable and its detection-on bit. Changing the detection-on bit changes the request output in the same cycle.
- R9: With detection off, line input activity never sets the pending flag.
- R10: A write to one line's word and activity on one line's input leave every other line's flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one line word |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 4 | Write-one action bits: 0 clear pending, 1 set pending, 2 clear enable, 3 set enable |
| rdAddr | input | ADDR_W | Read address, decoded combinationally |
| rdData | output | 4 | Read word: bit 0 pending, bit 1 enable |
| lineIn | input | NUM_LINES | Filtered, polarity-corrected line inputs |
| cfgDetEn | input | NUM_LINES | Per-line detection on |
| cfgEdge | input | NUM_LINES | Per-line mode: 1 edge, 0 level |
| irqReq | output | NUM_LINES | Per-line interrupt request |

## Verification
The bench builds the block with four lines, a 16-bit address, base 0x800 and an 8-byte stride. With four lines, two can run in edge mode and two in level mode at the same time, so each mode is checked while the other lines are active. The last line sits at 0x818, which puts the first address past the end (0x820) and an address below the base (0x7F8) inside the decode range under test. One test drives a hardware edge and a clear write into the same clock cycle.

// File: rtl/lineirq_pkg.sv
package lineirq_pkg;

  // write-one action bit positions inside a line word
  localparam int unsigned ACT_CLR_PEND = 0;
  localparam int unsigned ACT_SET_PEND = 1;
  localparam int unsigned ACT_CLR_ENA  = 2;
  localparam int unsigned ACT_SET_ENA  = 3;
  localparam int unsigned WORD_W       = 4;

  // strobes from the control to the datapath, one set per line
  typedef struct packed {
    logic clrPend;
    logic setPend;
    logic clrEna;
    logic setEna;
  } lineStb_t;

endpackage

// File: rtl/lineirq_ctl.sv
module lineirq_ctl
  import lineirq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h800,
  parameter int unsigned STRIDE_LOG2 = 3,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output lineStb_t          stb [NUM_LINES],
  output logic              rdHit,
  output logic [IDX_W-1:0]  rdIdx
);

  // returns {hit, index}
  function automatic logic [IDX_W:0] decodeAddr(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    logic              hit;
    off = a - BASE_ADDR;
    hit = (a >= BASE_ADDR) && (off[STRIDE_LOG2-1:0] == '0) &&
          ((off >> STRIDE_LOG2) < ADDR_W'(NUM_LINES));
    return {hit, off[STRIDE_LOG2 +: IDX_W]};
  endfunction

  logic [IDX_W:0]     wrDec;
  logic [IDX_W:0]     rdDec;
  logic [NUM_LINES-1:0] lineTouched;

  always_comb begin
    wrDec = decodeAddr(wrAddr);
    rdDec = decodeAddr(rdAddr);
  end

  assign rdHit = rdDec[IDX_W];
  assign rdIdx = rdDec[IDX_W-1:0];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic sel;
    assign sel = wrEn && wrDec[IDX_W] && (wrDec[IDX_W-1:0] == IDX_W'(i));
    assign stb[i].clrPend = sel && wrData[ACT_CLR_PEND];
    assign stb[i].setPend = sel && wrData[ACT_SET_PEND];
    assign stb[i].clrEna  = sel && wrData[ACT_CLR_ENA];
    assign stb[i].setEna  = sel && wrData[ACT_SET_ENA];
    assign lineTouched[i] = stb[i].clrPend | stb[i].setPend | stb[i].clrEna | stb[i].setEna;
  end

  // R10: one write reaches at most one line
  a_r10_single_line: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lineTouched));

endmodule

// File: rtl/lineirq_dp.sv
module lineirq_dp
  import lineirq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lineStb_t             stb [NUM_LINES],
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [NUM_LINES-1:0] cfgDetEn,
  input  logic [NUM_LINES-1:0] cfgEdge,
  output logic [NUM_LINES-1:0] pend,
  output logic [NUM_LINES-1:0] ena
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic prevIn;
    logic hwSet;

    always_comb begin
      if (cfgEdge[i]) hwSet = cfgDetEn[i] && lineIn[i] && !prevIn;
      else            hwSet = cfgDetEn[i] && lineIn[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevIn  <= 1'b0;
        pend[i] <= 1'b0;
        ena[i]  <= 1'b0;
      end else begin
        prevIn  <= lineIn[i];
        pend[i] <= hwSet || stb[i].setPend || (pend[i] && !stb[i].clrPend);
        ena[i]  <= stb[i].setEna || (ena[i] && !stb[i].clrEna);
      end
    end

    a_r3_edge_capture: assert property (@(posedge clk) disable iff (!rstN)
      (cfgDetEn[i] && cfgEdge[i] && lineIn[i] && !prevIn) |=> pend[i]);
    a_r4_sw_set: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].setPend |=> pend[i]);
    a_r4_clear_when_quiet: assert property (@(posedge clk) disable iff (!rstN)
      (stb[i].clrPend && !stb[i].setPend && !cfgDetEn[i]) |=> !pend[i]);
    a_r5_level_hold: assert property (@(posedge clk) disable iff (!rstN)
      (cfgDetEn[i] && !cfgEdge[i] && lineIn[i]) |=> pend[i]);
    a_r6_ena_set: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].setEna |=> ena[i]);
    a_r6_ena_clear: assert property (@(posedge clk) disable iff (!rstN)
      (stb[i].clrEna && !stb[i].setEna) |=> !ena[i]);
    a_r9_detect_off: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgDetEn[i] && !stb[i].setPend && !pend[i]) |=> !pend[i]);
  end

endmodule

// File: rtl/lineirq_status.sv
module lineirq_status
  import lineirq_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h800,
  parameter int unsigned STRIDE_LOG2 = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [3:0]           wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [3:0]           rdData,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [NUM_LINES-1:0] cfgDetEn,
  input  logic [NUM_LINES-1:0] cfgEdge,
  output logic [NUM_LINES-1:0] irqReq
);

  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  lineStb_t             stb [NUM_LINES];
  logic                 rdHit;
  logic [IDX_W-1:0]     rdIdx;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] ena;

  lineirq_ctl #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .STRIDE_LOG2(STRIDE_LOG2)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .stb(stb), .rdHit(rdHit), .rdIdx(rdIdx)
  );

  lineirq_dp #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .lineIn(lineIn),
    .cfgDetEn(cfgDetEn), .cfgEdge(cfgEdge), .pend(pend), .ena(ena)
  );

  always_comb begin
    rdData = '0;
    if (rdHit) begin
      rdData[0] = pend[rdIdx];
      rdData[1] = ena[rdIdx];
    end
  end

  assign irqReq = pend & ena & cfgDetEn;

  // R8: a request never leaves a line whose detection is off
  a_r8_req_gated: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & ~cfgDetEn) == '0);
  // R1: nothing is requested in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqReq == '0));

endmodule

// File: tb/lineirq_status_tb.sv
module lineirq_status_tb;
  localparam int N  = 4;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN;
  logic          wrEn;
  logic [AW-1:0] wrAddr;
  logic [3:0]    wrData;
  logic [AW-1:0] rdAddr;
  logic [3:0]    rdData;
  logic [N-1:0]  lineIn, cfgDetEn, cfgEdge, irqReq;

  typedef struct {
    logic [AW-1:0] addr;
    logic [3:0]    expRd;
    logic [N-1:0]  expIrq;
    string         tag;
  } item_t;

  item_t sbq[$];
  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  lineirq_status #(.NUM_LINES(N), .ADDR_W(AW), .BASE_ADDR(16'h0800), .STRIDE_LOG2(3)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .lineIn(lineIn), .cfgDetEn(cfgDetEn),
    .cfgEdge(cfgEdge), .irqReq(irqReq)
  );

  // monitor: pops expected items mid-cycle and compares against the ports
  always @(negedge clk) begin
    item_t it;
    #2;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      rdAddr = it.addr;
      #1;
      nRun++;
      if (rdData !== it.expRd || irqReq !== it.expIrq) begin
        nFail++;
        $display("FAIL %s: addr=%h rd=%h irq=%b expected rd=%h irq=%b",
                 it.tag, it.addr, rdData, irqReq, it.expRd, it.expIrq);
      end
    end
  end

  task automatic expectWord(input logic [AW-1:0] a, input logic [3:0] e,
                            input logic [N-1:0] ei, input string tag);
    item_t it;
    @(negedge clk);
    it.addr = a; it.expRd = e; it.expIrq = ei; it.tag = tag;
    sbq.push_back(it);
    #4;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPin(input int i, input logic v);
    @(negedge clk);
    lineIn[i] = v;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    lineIn = '0; cfgDetEn = '0; cfgEdge = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int i = 0; i < N; i++)
      expectWord(AW'(16'h0800 + 8 * i), 4'h0, 4'b0000, "R1 reset");

    cfgEdge  = 4'b0011;
    cfgDetEn = 4'b0111;

    // R6 R7: enable line 0 and read it back
    wr(16'h0800, 4'b1000);
    expectWord(16'h0800, 4'h2, 4'b0000, "R6 R7 enable set readback");

    // R3 R8: rising edge on line 0
    setPin(0, 1'b1);
    expectWord(16'h0800, 4'h3, 4'b0001, "R3 R8 edge captured");
    wr(16'h0800, 4'b0001);
    expectWord(16'h0800, 4'h2, 4'b0000, "R3 R4 clear with input held high");
    setPin(0, 1'b0);
    setPin(0, 1'b1);
    expectWord(16'h0800, 4'h3, 4'b0001, "R3 second edge");
    wr(16'h0800, 4'b0001);
    expectWord(16'h0800, 4'h2, 4'b0000, "R4 clear");

    // R4: hardware edge and clear in the same cycle on line 1
    @(negedge clk);
    lineIn[1] = 1'b1; wrEn = 1'b1; wrAddr = 16'h0808; wrData = 4'b0001;
    @(negedge clk);
    wrEn = 1'b0;
    expectWord(16'h0808, 4'h1, 4'b0000, "R4 hw set beats clear");
    wr(16'h0808, 4'b0011);
    expectWord(16'h0808, 4'h1, 4'b0000, "R4 sw set beats clear");
    wr(16'h0808, 4'b0001);
    expectWord(16'h0808, 4'h0, 4'b0000, "R4 clear line 1");

    // R5: level mode on line 2
    wr(16'h0810, 4'b1000);
    setPin(2, 1'b1);
    expectWord(16'h0810, 4'h3, 4'b0100, "R5 level sets");
    wr(16'h0810, 4'b0001);
    expectWord(16'h0810, 4'h3, 4'b0100, "R5 clear ignored while high");
    setPin(2, 1'b0);
    expectWord(16'h0810, 4'h3, 4'b0100, "R5 held after input low");
    wr(16'h0810, 4'b0001);
    expectWord(16'h0810, 4'h2, 4'b0000, "R5 clear after input low");

    // R9 R8: line 3 with detection off
    setPin(3, 1'b1);
    expectWord(16'h0818, 4'h0, 4'b0000, "R9 detection off ignores input");
    expectWord(16'h0818, 4'h0, 4'b0000, "R9 still clear");
    wr(16'h0818, 4'b0010);
    expectWord(16'h0818, 4'h1, 4'b0000, "R4 sw set with detection off");
    wr(16'h0818, 4'b1000);
    expectWord(16'h0818, 4'h3, 4'b0000, "R8 request gated by detection");
    @(negedge clk);
    cfgDetEn[3] = 1'b1;
    expectWord(16'h0818, 4'h3, 4'b1000, "R8 request follows detection");
    setPin(3, 1'b0);
    wr(16'h0818, 4'b0001);
    expectWord(16'h0818, 4'h2, 4'b0000, "R5 level line cleared");

    // R6: enable clear and simultaneous set/clear
    wr(16'h0818, 4'b0100);
    expectWord(16'h0818, 4'h0, 4'b0000, "R6 enable clear");
    wr(16'h0818, 4'b1100);
    expectWord(16'h0818, 4'h2, 4'b0000, "R6 set wins over clear");

    // R2 R10: stray writes touch nothing
    wr(16'h0804, 4'b0010);
    wr(16'h0820, 4'b0010);
    wr(16'h07F8, 4'b0010);
    expectWord(16'h0800, 4'h2, 4'b0000, "R2 R10 line 0 untouched");
    expectWord(16'h0808, 4'h0, 4'b0000, "R2 R10 line 1 untouched");
    expectWord(16'h0810, 4'h2, 4'b0000, "R2 R10 line 2 untouched");
    expectWord(16'h0818, 4'h2, 4'b0000, "R2 R10 line 3 untouched");
    expectWord(16'h0804, 4'h0, 4'b0000, "R2 unaligned read");
    expectWord(16'h0820, 4'h0, 4'b0000, "R2 out of range read");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule